// File: doc/BRIEF.md
# Fabric and processor memory ordering gate

This block merges two streams of memory requests, one from the processor and one from a reconfigurable fabric operation, onto a single load-store port. An operation is bracketed by a start pulse and a completion pulse. While it runs, the gate notes every aligned word that the fabric's requests name. A processor request to any other word goes through at once. A processor request to a noted word is stalled until the operation has completed. This keeps a later processor access from overtaking a fabric access to the same location.

The fabric issues its requests in program order and tags each one with a sequence number. The requests can reach the gate in a different order. The gate parks each arrival in a slot chosen by its tag and releases the slots strictly in tag order, beginning at zero for each operation. When the address set cannot be trusted, a sideband flag marks every processor request as conflicting. The same happens when more distinct words arrive than the table can hold.

All three data paths use valid/ready. A transfer takes place in a cycle where both valid and ready are high. A source that has raised valid keeps valid and its payload stable until the transfer. The gate never makes its memory-side valid depend on the memory-side ready, and once it offers a request to memory it keeps offering it until the transfer. The start, completion and unknown-address pins are plain control levels and pulses.

Top module: `mem_order_gate`

## Requirements
- R1: With no operation running, a valid processor request is offered to memory in the same cycle with mem_src = 0. It transfers in that cycle when mem_ready is high, provided no fabric request is waiting.
- R2: During an operation that has sent no fabric requests, processor requests pass with no added wait.
- R3: During an operation, a processor request whose word (addr[ADDR_W-1:2]) differs from every word the fabric has sent passes with no added wait.
- R4: A processor request whose word matches a recorded fabric word is held: cpu_req_ready stays low and memory does not see it. It is offered to memory in the cycle after the completion pulse.
- R5: A fabric request accepted in the same cycle counts as recorded, so a processor request to the same word in that cycle is held.
- R6: While an operation runs and fab_addr_unknown is high, every processor request is held.
- R7: The table holds TBL_DEPTH (default 8) distinct words. Up to that count, untouched words still pass. Once one more distinct word arrives, every processor request is held until completion.
- R8: Fabric requests reach memory in sequence order 0, 1, 2, … (modulo 2^SEQ_W), with mem_src = 1 and mem_seq carrying the tag. An arrival can be offered no earlier than the next cycle. fab_req_ready is low only while a request with the same tag is already waiting.
- R9: When a fabric request is waiting and a non-conflicting processor request is valid in the same cycle, the fabric request is offered first and the processor request goes in the next cycle.
- R10: The completion pulse empties the word table, discards waiting fabric requests and returns the expected tag to 0.
- R11: mem_valid does not depend on mem_ready. An offered request stays offered until it transfers. cpu_req_ready is high exactly in the cycles where the processor request transfers.
- R12: After reset, mem_valid is low, fab_req_ready is high, the table is empty and the expected tag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fab_start | input | 1 | Pulse: a fabric operation begins |
| fab_done | input | 1 | Pulse: the running operation has completed |
| fab_addr_unknown | input | 1 | Operation's address set is unknown; all processor requests conflict |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request accepted |
| cpu_req_addr | input | ADDR_W | Processor byte address |
| cpu_req_we | input | 1 | Processor write enable |
| cpu_req_wdata | input | DATA_W | Processor write data |
| fab_req_valid | input | 1 | Fabric request valid |
| fab_req_ready | output | 1 | Fabric request accepted into its slot |
| fab_req_seq | input | SEQ_W | Fabric program-order tag |
| fab_req_addr | input | ADDR_W | Fabric byte address |
| fab_req_we | input | 1 | Fabric write enable |
| fab_req_wdata | input | DATA_W | Fabric write data |
| mem_valid | output | 1 | Request offered to memory |
| mem_ready | input | 1 | Memory accepts the offered request |
| mem_addr | output | ADDR_W | Offered byte address |
| mem_we | output | 1 | Offered write enable |
| mem_wdata | output | DATA_W | Offered write data |
| mem_src | output | 1 | 0 = processor, 1 = fabric |
| mem_seq | output | SEQ_W | Tag of an offered fabric request |

## Verification
The bench sends fabric tags in a scrambled order and checks that memory sees them rising from zero. A gate that released on arrival would show tag 2 first. A gate that kept its tag counter across operations would stall the next operation's tag 0 and leave the scoreboard unfinished. Held processor requests are timed to the exact cycle after the completion pulse. This catches a gate that releases early, and also one that stays blocked when the table or the tag counter is not cleared. The bench probes a byte offset inside a recorded word, a word arriving in the same cycle as the processor request, a full table against one entry past full, a fabric-versus-processor tie, and a stalled memory port. Each of these shows up as a wrong wait count or a wrong scoreboard order when the gate mishandles it.

// File: rtl/mog_pkg.sv
package mog_pkg;
  typedef enum logic {
    SRC_CPU = 1'b0,
    SRC_FAB = 1'b1
  } src_e;

  localparam int WORD_BYTES_LOG2 = 2;
endpackage

// File: rtl/mog_reorder.sv
module mog_reorder #(
  parameter int SEQ_W  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_we,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              out_valid,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_we,
  output logic [DATA_W-1:0] out_wdata,
  input  logic              pop
);
  localparam int SLOTS = 1 << SEQ_W;

  logic [SLOTS-1:0]  occ_q;
  logic [SEQ_W-1:0]  exp_q;
  logic [ADDR_W-1:0] addr_q  [SLOTS];
  logic              we_q    [SLOTS];
  logic [DATA_W-1:0] wdata_q [SLOTS];
  logic              take;

  assign in_ready  = !occ_q[in_seq];
  assign take      = in_valid && in_ready && !clr;
  assign out_valid = occ_q[exp_q];
  assign out_seq   = exp_q;
  assign out_addr  = addr_q[exp_q];
  assign out_we    = we_q[exp_q];
  assign out_wdata = wdata_q[exp_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
      exp_q <= '0;
    end else if (clr) begin
      occ_q <= '0;
      exp_q <= '0;
    end else begin
      if (take) occ_q[in_seq] <= 1'b1;
      if (pop && occ_q[exp_q]) begin
        occ_q[exp_q] <= 1'b0;
        exp_q        <= exp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q[in_seq]  <= in_addr;
      we_q[in_seq]    <= in_we;
      wdata_q[in_seq] <= in_wdata;
    end
  end
endmodule

// File: rtl/mog_addr_table.sv
module mog_addr_table #(
  parameter int WORD_W = 30,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rec_en,
  input  logic [WORD_W-1:0] rec_word,
  input  logic [WORD_W-1:0] q_word,
  output logic              q_hit,
  output logic              ovf
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] ent_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;
  logic [DEPTH-1:0]  q_match, r_match;
  logic              is_new, full, wr_en;
  logic [IDX_W-1:0]  wr_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign q_match[i] = vld_q[i] && (ent_q[i] == q_word);
    assign r_match[i] = vld_q[i] && (ent_q[i] == rec_word);
  end

  assign q_hit  = |q_match;
  assign ovf    = ovf_q;
  assign is_new = rec_en && !(|r_match);
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign wr_en  = is_new && !full && !clr;
  assign wr_idx = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      vld_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (is_new) begin
      if (full) begin
        ovf_q <= 1'b1;
      end else begin
        vld_q[wr_idx] <= 1'b1;
        cnt_q         <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent_q[wr_idx] <= rec_word;
  end
endmodule

// File: rtl/mog_arbiter.sv
module mog_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic fab_cand,
  input  logic cpu_valid,
  input  logic cpu_conflict,
  input  logic mem_ready,
  output logic grant_fab,
  output logic grant_cpu
);
  logic cpu_lock_q;

  assign grant_cpu = cpu_valid && (cpu_lock_q || (!fab_cand && !cpu_conflict));
  assign grant_fab = fab_cand && !cpu_lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_lock_q <= 1'b0;
    else        cpu_lock_q <= grant_cpu && !mem_ready;
  end
endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SEQ_W     = 4,
  parameter int TBL_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fab_start,
  input  logic              fab_done,
  input  logic              fab_addr_unknown,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic              cpu_req_we,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  input  logic              fab_req_valid,
  output logic              fab_req_ready,
  input  logic [SEQ_W-1:0]  fab_req_seq,
  input  logic [ADDR_W-1:0] fab_req_addr,
  input  logic              fab_req_we,
  input  logic [DATA_W-1:0] fab_req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_src,
  output logic [SEQ_W-1:0]  mem_seq
);
  import mog_pkg::*;

  localparam int WB     = WORD_BYTES_LOG2;
  localparam int WORD_W = ADDR_W - WB;

  logic              busy_q;
  logic              fab_acc, in_hit, tbl_hit, tbl_ovf, conflict;
  logic              rob_valid, rob_we, grant_fab, grant_cpu;
  logic [SEQ_W-1:0]  rob_seq;
  logic [ADDR_W-1:0] rob_addr;
  logic [DATA_W-1:0] rob_wdata;
  logic [WORD_W-1:0] cpu_word, fab_word;

  assign cpu_word = cpu_req_addr[ADDR_W-1:WB];
  assign fab_word = fab_req_addr[ADDR_W-1:WB];

  always_ff @(posedge clk) begin
    if (!rst_n || fab_done) busy_q <= 1'b0;
    else if (fab_start)     busy_q <= 1'b1;
  end

  mog_reorder #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rob (
    .clk, .rst_n, .clr(fab_done),
    .in_valid(fab_req_valid), .in_ready(fab_req_ready), .in_seq(fab_req_seq),
    .in_addr(fab_req_addr), .in_we(fab_req_we), .in_wdata(fab_req_wdata),
    .out_valid(rob_valid), .out_seq(rob_seq), .out_addr(rob_addr),
    .out_we(rob_we), .out_wdata(rob_wdata), .pop(grant_fab && mem_ready)
  );

  assign fab_acc = fab_req_valid && fab_req_ready;
  assign in_hit  = fab_acc && (fab_word == cpu_word);

  mog_addr_table #(.WORD_W(WORD_W), .DEPTH(TBL_DEPTH)) u_tbl (
    .clk, .rst_n, .clr(fab_done),
    .rec_en(fab_acc), .rec_word(fab_word),
    .q_word(cpu_word), .q_hit(tbl_hit), .ovf(tbl_ovf)
  );

  assign conflict = busy_q && (fab_addr_unknown || tbl_ovf || tbl_hit || in_hit);

  mog_arbiter u_arb (
    .clk, .rst_n, .fab_cand(rob_valid), .cpu_valid(cpu_req_valid),
    .cpu_conflict(conflict), .mem_ready,
    .grant_fab, .grant_cpu
  );

  assign cpu_req_ready = grant_cpu && mem_ready;
  assign mem_valid     = grant_fab || grant_cpu;

  always_comb begin
    if (grant_fab) begin
      mem_addr  = rob_addr;
      mem_we    = rob_we;
      mem_wdata = rob_wdata;
      mem_src   = SRC_FAB;
      mem_seq   = rob_seq;
    end else begin
      mem_addr  = cpu_req_addr;
      mem_we    = cpu_req_we;
      mem_wdata = cpu_req_wdata;
      mem_src   = SRC_CPU;
      mem_seq   = '0;
    end
  end
endmodule

// File: rtl/mog_checks.sv
module mog_checks #(
  parameter int SEQ_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fab_start,
  input logic             fab_done,
  input logic             fab_addr_unknown,
  input logic             cpu_req_valid,
  input logic             cpu_req_ready,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic             mem_src,
  input logic [SEQ_W-1:0] mem_seq
);
  logic             ck_busy;
  logic [SEQ_W-1:0] ck_exp;

  always_ff @(posedge clk) begin
    if (!rst_n || fab_done) ck_busy <= 1'b0;
    else if (fab_start)     ck_busy <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fab_done) ck_exp <= '0;
    else if (mem_valid && mem_ready && mem_src) ck_exp <= ck_exp + 1'b1;
  end

  AST_FAB_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_src |-> mem_seq == ck_exp); // R8

  AST_CPU_READY_IS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> mem_valid && mem_ready && !mem_src); // R11

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready && !fab_done |=> mem_valid); // R11

  AST_UNKNOWN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ck_busy && fab_addr_unknown && !$past(mem_valid && !mem_ready)
      |-> !(mem_valid && !mem_src)); // R6

  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fab_done) && cpu_req_valid |-> mem_valid && !mem_src); // R4

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_busy && cpu_req_valid && !(mem_valid && mem_src) |-> mem_valid); // R1
endmodule

bind mem_order_gate mog_checks #(.SEQ_W(SEQ_W)) u_mog_checks (
  .clk(clk), .rst_n(rst_n), .fab_start(fab_start), .fab_done(fab_done),
  .fab_addr_unknown(fab_addr_unknown), .cpu_req_valid(cpu_req_valid),
  .cpu_req_ready(cpu_req_ready), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_src(mem_src), .mem_seq(mem_seq)
);

// File: tb/test_mem_order_gate.sv
`timescale 1ns/100ps
module test_mem_order_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fab_start = 1'b0, fab_done = 1'b0, fab_addr_unknown = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic        cpu_req_ready;
  logic        fab_req_valid = 1'b0, fab_req_we = 1'b0;
  logic [3:0]  fab_req_seq = '0;
  logic [31:0] fab_req_addr = '0, fab_req_wdata = '0;
  logic        fab_req_ready;
  logic        mem_valid, mem_we, mem_src;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_seq;
  logic        mem_stall = 1'b0;
  logic        mem_ready;

  assign mem_ready = !mem_stall;
  always #2.5 clk = ~clk;

  mem_order_gate i_mem_order_gate (
    .clk, .rst_n, .fab_start, .fab_done, .fab_addr_unknown,
    .cpu_req_valid, .cpu_req_ready, .cpu_req_addr, .cpu_req_we, .cpu_req_wdata,
    .fab_req_valid, .fab_req_ready, .fab_req_seq, .fab_req_addr, .fab_req_we,
    .fab_req_wdata, .mem_valid, .mem_ready, .mem_addr, .mem_we, .mem_wdata,
    .mem_src, .mem_seq
  );

  typedef struct {
    logic        src;
    logic [31:0] addr;
    logic        we;
    logic [31:0] data;
    logic [3:0]  seq;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic push(logic src, logic [31:0] a, logic we, logic [31:0] d,
                      logic [3:0] s, string tag);
    item_t it;
    it.src = src; it.addr = a; it.we = we; it.data = d; it.seq = s; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic cpu_go(logic [31:0] a, logic we, logic [31:0] d, string tag,
                        output int waited);
    push(1'b0, a, we, d, 4'd0, tag);
    cpu_req_addr = a; cpu_req_we = we; cpu_req_wdata = d; cpu_req_valid = 1'b1;
    waited = 0;
    forever begin
      @(negedge clk);
      if (cpu_req_ready) break;
      waited++;
      if (waited > 400) break;
    end
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
  endtask

  task automatic fab_put(logic [3:0] s, logic [31:0] a, logic [31:0] d,
                         output logic rdy);
    fab_req_seq = s; fab_req_addr = a; fab_req_we = 1'b1; fab_req_wdata = d;
    fab_req_valid = 1'b1;
    @(negedge clk);
    rdy = fab_req_ready;
    @(posedge clk); #1;
    fab_req_valid = 1'b0;
  endtask

  task automatic pulse_start;
    fab_start = 1'b1; step; fab_start = 1'b0;
  endtask

  task automatic pulse_done;
    fab_done = 1'b1; step; fab_done = 1'b0;
  endtask

  // Monitor: compares every memory-side transfer against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R8/R10 unexpected transfer: actual src %0d addr %0h seq %0d expected none",
                 mem_src, mem_addr, mem_seq);
      end else begin
        item_t e;
        e = sb.pop_front();
        chk(e.tag, "mem_src", 64'(mem_src), 64'(e.src));
        chk(e.tag, "mem_addr", 64'(mem_addr), 64'(e.addr));
        chk(e.tag, "mem_we", 64'(mem_we), 64'(e.we));
        if (e.we) chk(e.tag, "mem_wdata", 64'(mem_wdata), 64'(e.data));
        if (e.src) chk(e.tag, "mem_seq", 64'(mem_seq), 64'(e.seq));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int   w;
    logic r;
    // R12 reset state
    repeat (3) step;
    @(negedge clk);
    chk("R12", "mem_valid in reset", 64'(mem_valid), 64'd0);
    chk("R12", "fab_req_ready in reset", 64'(fab_req_ready), 64'd1);
    step;
    rst_n = 1'b1;
    step;

    // R1 idle pass-through
    cpu_go(32'h100, 1'b1, 32'hA1, "R1", w);
    chk("R1", "idle write wait", 64'(w), 64'd0);
    cpu_go(32'h104, 1'b0, 32'h0, "R1", w);
    chk("R1", "idle read wait", 64'(w), 64'd0);

    // R11 memory back-pressure keeps the offer up
    mem_stall = 1'b1;
    fork
      cpu_go(32'h900, 1'b1, 32'h5A5A, "R11", w);
      begin
        repeat (3) begin
          @(negedge clk);
          chk("R11", "mem_valid while stalled", 64'(mem_valid), 64'd1);
          chk("R11", "cpu_req_ready while stalled", 64'(cpu_req_ready), 64'd0);
          chk("R11", "mem_addr while stalled", 64'(mem_addr), 64'h900);
        end
        @(posedge clk); #1;
        mem_stall = 1'b0;
      end
    join
    chk("R11", "stalled wait", 64'(w), 64'd3);

    // R2 operation with no fabric accesses
    pulse_start;
    cpu_go(32'h600, 1'b1, 32'h66, "R2", w);
    chk("R2", "wait during access-free op", 64'(w), 64'd0);
    pulse_done;

    // R8 scrambled arrival, in-order release
    pulse_start;
    for (int i = 0; i < 4; i++)
      push(1'b1, 32'h200 + 32'(4 * i), 1'b1, 32'hF0 + 32'(i), 4'(i), "R8");
    fab_put(4'd2, 32'h208, 32'hF2, r); chk("R8", "ready tag2", 64'(r), 64'd1);
    fab_put(4'd0, 32'h200, 32'hF0, r); chk("R8", "ready tag0", 64'(r), 64'd1);
    fab_put(4'd3, 32'h20C, 32'hF3, r); chk("R8", "ready tag3", 64'(r), 64'd1);
    fab_put(4'd1, 32'h204, 32'hF1, r); chk("R8", "ready tag1", 64'(r), 64'd1);
    repeat (6) step;
    chk("R8", "all four released", 64'(sb.size()), 64'd0);

    // R3 disjoint word passes during the operation
    cpu_go(32'h300, 1'b0, 32'h0, "R3", w);
    chk("R3", "disjoint wait", 64'(w), 64'd0);

    // R8 duplicate tag refused while its slot waits
    fab_put(4'd5, 32'h2F0, 32'h55, r); chk("R8", "ready tag5", 64'(r), 64'd1);
    fab_put(4'd5, 32'h2F4, 32'h56, r); chk("R8", "ready duplicate tag5", 64'(r), 64'd0);

    // R4 overlapping word (byte offset inside recorded word 0x204) held until done
    fork
      cpu_go(32'h206, 1'b0, 32'h0, "R4", w);
      begin repeat (10) step; pulse_done; end
    join
    chk("R4", "held until cycle after done", 64'(w), 64'd11);

    // R10 done cleared tag counter, table and the waiting tag 5
    pulse_start;
    push(1'b1, 32'h400, 1'b1, 32'hB0, 4'd0, "R10");
    push(1'b1, 32'h404, 1'b1, 32'hB1, 4'd1, "R10");
    fab_put(4'd1, 32'h404, 32'hB1, r);
    fab_put(4'd0, 32'h400, 32'hB0, r);
    repeat (4) step;
    chk("R10", "new op released from tag 0", 64'(sb.size()), 64'd0);
    cpu_go(32'h208, 1'b0, 32'h0, "R10", w);
    chk("R10", "old word no longer recorded", 64'(w), 64'd0);
    pulse_done;

    // R9 fabric wins a same-cycle tie
    pulse_start;
    push(1'b1, 32'h800, 1'b1, 32'hC0, 4'd0, "R9");
    fab_put(4'd0, 32'h800, 32'hC0, r);
    cpu_go(32'hA00, 1'b1, 32'hC1, "R9", w);
    chk("R9", "processor retries next cycle", 64'(w), 64'd1);
    pulse_done;

    // R5 same-cycle arrival counts as recorded
    pulse_start;
    push(1'b1, 32'h700, 1'b1, 32'hD0, 4'd0, "R5");
    fab_req_seq = 4'd0; fab_req_addr = 32'h700; fab_req_we = 1'b1;
    fab_req_wdata = 32'hD0; fab_req_valid = 1'b1;
    fork
      cpu_go(32'h702, 1'b0, 32'h0, "R5", w);
      begin step; fab_req_valid = 1'b0; repeat (5) step; pulse_done; end
    join
    chk("R5", "held against same-cycle arrival", 64'(w), 64'd7);

    // R6 unknown addresses hold everything
    fab_addr_unknown = 1'b1;
    pulse_start;
    fork
      cpu_go(32'h5000, 1'b1, 32'hE0, "R6", w);
      begin repeat (4) step; pulse_done; end
    join
    chk("R6", "held under unknown flag", 64'(w), 64'd5);
    fab_addr_unknown = 1'b0;

    // R7 full table still discriminates, one more word overflows
    pulse_start;
    for (int i = 0; i < 8; i++) begin
      push(1'b1, 32'h1000 + 32'(4 * i), 1'b1, 32'(i), 4'(i), "R7");
      fab_put(4'(i), 32'h1000 + 32'(4 * i), 32'(i), r);
    end
    repeat (4) step;
    cpu_go(32'h3000, 1'b0, 32'h0, "R7", w);
    chk("R7", "untouched word with full table", 64'(w), 64'd0);
    push(1'b1, 32'h1020, 1'b1, 32'h8, 4'd8, "R7");
    fab_put(4'd8, 32'h1020, 32'h8, r);
    repeat (2) step;
    fork
      cpu_go(32'h3000, 1'b0, 32'h0, "R7", w);
      begin repeat (4) step; pulse_done; end
    join
    chk("R7", "held after overflow", 64'(w), 64'd5);

    repeat (5) step;
    chk("R8", "scoreboard drained", 64'(sb.size()), 64'd0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule